// File: doc/BRIEF.md
# Page Residency Use-Count Tracker

This block keeps a small fully associative table of page tags for a cache controller that works line by line. Each live entry holds the number of cache lines from that page that are now resident in the cache. When the controller fills a line it sends an add command. When it evicts a line it sends a remove command. Before a fill it can probe whether the page is known. A probe that finds no entry raises a map-miss indication and bumps a saturating miss counter. An entry whose count falls to zero goes back to the free pool.

Commands arrive on a valid/ready port with a 2-bit opcode and a line address. The page tag is the line address with its in-page offset bits dropped. A command is accepted in any cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` then stays low for one cycle while the table compares every tag in parallel and applies the update. The sender must hold `cmd_valid`, `cmd_op` and `cmd_addr` until it sees `cmd_ready`. The result appears as a one-cycle `rsp_valid` pulse with no back-pressure, because the controller that issued the command is always waiting for it. Opcodes are: 00 probe, 01 add-line, 10 remove-line, 11 flush.

Top module: `page_use_tracker`

## Requirements
- R1: After reset `cmd_ready` is 1, `rsp_valid` is 0, `live_count` is 0 and `miss_count` is 0.
- R2: A command accepted at clock edge k drives `cmd_ready` low until edge k+1. `rsp_valid` is high for exactly the cycle after edge k+1. `rsp_hit`, `rsp_map_miss` and `rsp_overflow` are 0 whenever `rsp_valid` is 0.
- R3: The page tag is `cmd_addr[LINE_AW-1:PAGE_BITS]`. Addresses that differ only in bits `[PAGE_BITS-1:0]` refer to the same entry.
- R4: A probe (op 00) of an untracked page returns `rsp_map_miss`=1 and `rsp_hit`=0. It allocates nothing and increments `miss_count`.
- R5: A probe of a tracked page returns `rsp_hit`=1 and that entry's count in `rsp_count`. It changes no state.
- R6: An add (op 01) to a tracked page increments its count and returns `rsp_hit`=1 with the new count. `live_count` is unchanged.
- R7: An add to an untracked page claims a free entry with count 1 and returns `rsp_hit`=0 and `rsp_count`=1. `live_count` rises by one and never exceeds ENTRIES.
- R8: A remove (op 10) of a tracked page decrements its count and returns the new count. When the count reaches 0, the entry is freed and `live_count` falls by one.
- R9: A remove of an untracked page is legal. It returns `rsp_hit`=0 and leaves the table and `live_count` unchanged.
- R10: An add to an untracked page while all ENTRIES entries are live returns `rsp_overflow`=1. The add is dropped and `live_count` is unchanged.
- R11: A flush (op 11) frees every entry and sets `live_count` to 0. It leaves `miss_count` unchanged.
- R12: `miss_count` saturates at all ones.
- R13: An add to a tracked page whose count is already all ones returns `rsp_overflow`=1. The count stays at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 2 | 00 probe, 01 add, 10 remove, 11 flush |
| cmd_addr | input | LINE_AW | Line address |
| rsp_valid | output | 1 | Result pulse |
| rsp_hit | output | 1 | Page was tracked |
| rsp_map_miss | output | 1 | Probe found no entry |
| rsp_overflow | output | 1 | Add dropped (table full or count at maximum) |
| rsp_count | output | COUNT_W | Entry count after the command, 0 if none |
| live_count | output | $clog2(ENTRIES+1) | Number of live entries |
| miss_count | output | MISS_W | Saturating probe-miss counter |

## Verification
The bench builds the tracker with ENTRIES=4, COUNT_W=3 and MISS_W=3, and keeps the 32-bit address with 12 offset bits. Four distinct pages are then enough to fill the table, so the full-table overflow is reached. Seven adds to one page bring its count to its maximum. Seven probe misses drive the miss counter into saturation. None of these limits is reachable in a short directed run at the default sizes.

// File: rtl/page_use_pkg.sv
package page_use_pkg;
  typedef enum logic [1:0] {
    OP_PROBE = 2'b00,
    OP_ADD   = 2'b01,
    OP_DROP  = 2'b10,
    OP_CLEAR = 2'b11
  } puse_op_e;
endpackage

// File: rtl/page_use_match.sv
// Parallel tag compare across all live entries; one-hot hit vector and index.
module page_use_match #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 20,
  parameter int COUNT_W = 14,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0][TAG_W-1:0]   tags,
  input  logic [ENTRIES-1:0][COUNT_W-1:0] counts,
  input  logic [TAG_W-1:0]                key,
  output logic                            any_hit,
  output logic [IDX_W-1:0]                hit_idx
);
  logic [ENTRIES-1:0] hit_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    // An entry is live while its count is non-zero.
    assign hit_vec[g] = (counts[g] != '0) && (tags[g] == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign any_hit = |hit_vec;
endmodule

// File: rtl/page_use_alloc.sv
// Picks the lowest-numbered free entry (count of zero).
module page_use_alloc #(
  parameter int ENTRIES = 16,
  parameter int COUNT_W = 14,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0][COUNT_W-1:0] counts,
  output logic                            any_free,
  output logic [IDX_W-1:0]                free_idx
);
  logic [ENTRIES-1:0] free_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_free
    assign free_vec[g] = (counts[g] == '0);
  end

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (free_vec[i]) free_idx = IDX_W'(i);
    end
  end

  assign any_free = |free_vec;
endmodule

// File: rtl/page_use_satcnt.sv
// Saturating event counter, cleared by reset.
module page_use_satcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bump,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
    end else if (bump && (value != {W{1'b1}})) begin
      value <= value + W'(1);
    end
  end
endmodule

// File: rtl/page_use_tracker.sv
module page_use_tracker #(
  parameter int ENTRIES   = 16,
  parameter int LINE_AW   = 32,
  parameter int PAGE_BITS = 12,
  parameter int COUNT_W   = 14,
  parameter int MISS_W    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  output logic                         cmd_ready,
  input  logic [1:0]                   cmd_op,
  input  logic [LINE_AW-1:0]           cmd_addr,
  output logic                         rsp_valid,
  output logic                         rsp_hit,
  output logic                         rsp_map_miss,
  output logic                         rsp_overflow,
  output logic [COUNT_W-1:0]           rsp_count,
  output logic [$clog2(ENTRIES+1)-1:0] live_count,
  output logic [MISS_W-1:0]            miss_count
);
  import page_use_pkg::*;

  localparam int TAG_W  = LINE_AW - PAGE_BITS;
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int LIVE_W = $clog2(ENTRIES + 1);
  localparam logic [COUNT_W-1:0] COUNT_MAX = {COUNT_W{1'b1}};

  logic                            busy;
  puse_op_e                        op_q;
  logic [TAG_W-1:0]                tag_q;
  logic [ENTRIES-1:0][TAG_W-1:0]   tags;
  logic [ENTRIES-1:0][COUNT_W-1:0] counts;

  logic             any_hit, any_free;
  logic [IDX_W-1:0] hit_idx, free_idx;
  logic [COUNT_W-1:0] hit_cnt;
  logic             miss_bump;
  logic             unused_ofs;

  assign unused_ofs = ^cmd_addr[PAGE_BITS-1:0];
  assign cmd_ready  = !busy;

  page_use_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .COUNT_W(COUNT_W), .IDX_W(IDX_W)) u_match (
    .tags(tags), .counts(counts), .key(tag_q), .any_hit(any_hit), .hit_idx(hit_idx)
  );

  page_use_alloc #(.ENTRIES(ENTRIES), .COUNT_W(COUNT_W), .IDX_W(IDX_W)) u_alloc (
    .counts(counts), .any_free(any_free), .free_idx(free_idx)
  );

  assign hit_cnt   = counts[hit_idx];
  assign miss_bump = busy && (op_q == OP_PROBE) && !any_hit;

  page_use_satcnt #(.W(MISS_W)) u_miss (
    .clk(clk), .rst_n(rst_n), .bump(miss_bump), .value(miss_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      op_q         <= OP_PROBE;
      tag_q        <= '0;
      tags         <= '0;
      counts       <= '0;
      live_count   <= '0;
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_map_miss <= 1'b0;
      rsp_overflow <= 1'b0;
      rsp_count    <= '0;
    end else begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_map_miss <= 1'b0;
      rsp_overflow <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          busy  <= 1'b1;
          op_q  <= puse_op_e'(cmd_op);
          tag_q <= cmd_addr[LINE_AW-1:PAGE_BITS];
        end
      end else begin
        busy      <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_count <= '0;
        unique case (op_q)
          OP_PROBE: begin
            rsp_hit      <= any_hit;
            rsp_map_miss <= !any_hit;
            if (any_hit) rsp_count <= hit_cnt;
          end
          OP_ADD: begin
            if (any_hit) begin
              rsp_hit <= 1'b1;
              if (hit_cnt == COUNT_MAX) begin
                rsp_overflow <= 1'b1;
                rsp_count    <= hit_cnt;
              end else begin
                counts[hit_idx] <= hit_cnt + COUNT_W'(1);
                rsp_count       <= hit_cnt + COUNT_W'(1);
              end
            end else if (any_free) begin
              tags[free_idx]   <= tag_q;
              counts[free_idx] <= COUNT_W'(1);
              live_count       <= live_count + LIVE_W'(1);
              rsp_count        <= COUNT_W'(1);
            end else begin
              rsp_overflow <= 1'b1;
            end
          end
          OP_DROP: begin
            if (any_hit) begin
              rsp_hit         <= 1'b1;
              counts[hit_idx] <= hit_cnt - COUNT_W'(1);
              rsp_count       <= hit_cnt - COUNT_W'(1);
              if (hit_cnt == COUNT_W'(1)) live_count <= live_count - LIVE_W'(1);
            end
          end
          OP_CLEAR: begin
            counts     <= '0;
            live_count <= '0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/page_use_tracker_chk.sv
module page_use_tracker_chk #(
  parameter int ENTRIES = 16,
  parameter int MISS_W  = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cmd_valid,
  input logic                         cmd_ready,
  input logic                         rsp_valid,
  input logic                         rsp_hit,
  input logic                         rsp_map_miss,
  input logic                         rsp_overflow,
  input logic [$clog2(ENTRIES+1)-1:0] live_count,
  input logic [MISS_W-1:0]            miss_count
);
  AST_ACCEPT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R2
  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |-> ##2 rsp_valid); // R2
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R2
  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_map_miss || rsp_overflow)); // R2
  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit && rsp_map_miss)); // R4
  AST_MISS_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_map_miss && $past(rst_n)) |-> $stable(live_count)); // R4
  AST_LIVE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    live_count <= ($clog2(ENTRIES+1))'(ENTRIES)); // R7
  AST_NO_OVERFLOW_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_overflow && $past(rst_n)) |-> $stable(live_count)); // R10
  AST_MISS_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (miss_count >= $past(miss_count))); // R12
endmodule

bind page_use_tracker page_use_tracker_chk #(.ENTRIES(ENTRIES), .MISS_W(MISS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_map_miss(rsp_map_miss),
  .rsp_overflow(rsp_overflow), .live_count(live_count), .miss_count(miss_count)
);

// File: tb/page_use_tracker_tb.sv
module page_use_tracker_tb;
  localparam int ENTRIES = 4;
  localparam int COUNT_W = 3;
  localparam int MISS_W  = 3;
  localparam int LIVE_W  = $clog2(ENTRIES + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'b00;
  logic [31:0] cmd_addr = '0;
  logic rsp_valid, rsp_hit, rsp_map_miss, rsp_overflow;
  logic [COUNT_W-1:0] rsp_count;
  logic [LIVE_W-1:0] live_count;
  logic [MISS_W-1:0] miss_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic r_hit, r_miss, r_ovf;
  logic [COUNT_W-1:0] r_cnt;

  always #4 clk = ~clk;

  page_use_tracker #(.ENTRIES(ENTRIES), .LINE_AW(32), .PAGE_BITS(12),
                     .COUNT_W(COUNT_W), .MISS_W(MISS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_map_miss(rsp_map_miss), .rsp_overflow(rsp_overflow), .rsp_count(rsp_count),
    .live_count(live_count), .miss_count(miss_count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issue one command and capture its result; checks the handshake timing (R2).
  task automatic do_cmd(input logic [1:0] op, input logic [31:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready === 1'b0 && rsp_valid === 1'b0, "R2 busy", int'(cmd_ready), 0);
    @(negedge clk);
    chk(rsp_valid === 1'b1 && cmd_ready === 1'b1, "R2 response", int'(rsp_valid), 1);
    r_hit = rsp_hit; r_miss = rsp_map_miss; r_ovf = rsp_overflow; r_cnt = rsp_count;
    @(negedge clk);
    chk(rsp_valid === 1'b0 && rsp_hit === 1'b0, "R2 pulse", int'(rsp_valid), 0);
  endtask

  task automatic t_reset();
    chk(cmd_ready === 1'b1, "R1 ready", int'(cmd_ready), 1);
    chk(rsp_valid === 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
    chk(live_count == 0, "R1 live", int'(live_count), 0);
    chk(miss_count == 0, "R1 miss", int'(miss_count), 0);
  endtask

  task automatic t_probe_miss();
    do_cmd(2'b00, 32'h1234_5678);
    chk(r_miss && !r_hit, "R4 map miss", int'(r_miss), 1);
    chk(live_count == 0, "R4 no alloc", int'(live_count), 0);
    chk(miss_count == 1, "R4 miss count", int'(miss_count), 1);
  endtask

  task automatic t_add_and_probe();
    do_cmd(2'b01, 32'h0000_3010);
    chk(!r_hit && r_cnt == 1, "R7 alloc count", int'(r_cnt), 1);
    chk(live_count == 1, "R7 live", int'(live_count), 1);
    do_cmd(2'b01, 32'h0000_3FF0);
    chk(r_hit && r_cnt == 2, "R6 R3 increment", int'(r_cnt), 2);
    chk(live_count == 1, "R6 live unchanged", int'(live_count), 1);
    do_cmd(2'b00, 32'h0000_3000);
    chk(r_hit && !r_miss && r_cnt == 2, "R5 probe hit", int'(r_cnt), 2);
    chk(miss_count == 1, "R5 miss count unchanged", int'(miss_count), 1);
  endtask

  task automatic t_remove();
    do_cmd(2'b10, 32'h0000_3ABC);
    chk(r_hit && r_cnt == 1, "R8 decrement", int'(r_cnt), 1);
    chk(live_count == 1, "R8 still live", int'(live_count), 1);
    do_cmd(2'b10, 32'h0000_3004);
    chk(r_cnt == 0 && live_count == 0, "R8 freed", int'(live_count), 0);
    do_cmd(2'b00, 32'h0000_3000);
    chk(r_miss && miss_count == 2, "R8 gone after free", int'(miss_count), 2);
  endtask

  task automatic t_remove_absent();
    do_cmd(2'b10, 32'h0000_9000);
    chk(!r_hit && !r_ovf && !r_miss, "R9 flags", int'(r_hit), 0);
    chk(live_count == 0, "R9 live unchanged", int'(live_count), 0);
    do_cmd(2'b00, 32'h0000_9000);
    chk(r_miss && miss_count == 3, "R9 no entry made", int'(miss_count), 3);
  endtask

  task automatic t_count_sat();
    for (int i = 1; i <= 7; i++) do_cmd(2'b01, 32'h0000_5000 + 32'(i));
    chk(r_cnt == 7 && !r_ovf, "R13 reach max", int'(r_cnt), 7);
    do_cmd(2'b01, 32'h0000_5800);
    chk(r_ovf && r_hit && r_cnt == 7, "R13 saturate", int'(r_cnt), 7);
    do_cmd(2'b00, 32'h0000_5000);
    chk(r_cnt == 7, "R13 count held", int'(r_cnt), 7);
    chk(live_count == 1, "R13 live", int'(live_count), 1);
  endtask

  task automatic t_full();
    do_cmd(2'b01, 32'h0000_6000);
    do_cmd(2'b01, 32'h0000_7000);
    do_cmd(2'b01, 32'h0000_8000);
    chk(live_count == 4, "R7 fill", int'(live_count), 4);
    do_cmd(2'b01, 32'h0000_A000);
    chk(r_ovf && !r_hit, "R10 overflow", int'(r_ovf), 1);
    chk(live_count == 4, "R10 live held", int'(live_count), 4);
    do_cmd(2'b00, 32'h0000_A000);
    chk(r_miss && miss_count == 4, "R10 add dropped", int'(miss_count), 4);
  endtask

  task automatic t_miss_sat();
    for (int i = 0; i < 4; i++) do_cmd(2'b00, 32'h0000_B000);
    chk(miss_count == 7, "R12 saturate", int'(miss_count), 7);
  endtask

  task automatic t_flush();
    do_cmd(2'b11, 32'h0);
    chk(live_count == 0, "R11 live cleared", int'(live_count), 0);
    chk(miss_count == 7, "R11 miss kept", int'(miss_count), 7);
    do_cmd(2'b00, 32'h0000_5000);
    chk(r_miss && !r_hit, "R11 entry gone", int'(r_hit), 0);
    do_cmd(2'b01, 32'h0000_5000);
    chk(!r_hit && r_cnt == 1 && live_count == 1, "R11 reuse", int'(r_cnt), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_probe_miss();
    t_add_and_probe();
    t_remove();
    t_remove_absent();
    t_count_sat();
    t_full();
    t_miss_sat();
    t_flush();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule